// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Event Capture

The block is one bank of general-purpose pins. Each pin is set as an input or an output, and as an output it drives a value held in a register. When the chip is in sleep it drives a sleep value instead. When a battery fault is signalled it drives a fault value instead. Each pin also has an event detector. The detector watches a synchronized copy of the raw pin level and can look for a level (high or low) or an edge (rising or falling). A detected event is latched in a sticky status register. Software clears a status bit by writing 1 to it.

All status bits whose blocking bit is 0 are ORed into one interrupt line. While the sleep input is high, a separate sleep blocking register is used in place of the normal one. Software reaches the bank through a word-addressed register port. Writes take effect on the clock edge. Reads are combinational on the address.

Top module: `gpio_bank`

## Requirements
- R1: While reset is low, all configuration registers, the status register and the input synchronizer flops are 0. So pin_oe=0, pin_out=0 and irq=0, and every register reads 0.
- R2: Register word index is bus_addr[5:2]. The index-to-register map is:

  | Index | Register |
  |---|---|
  | 0 | interrupt block |
  | 1 | direction |
  | 2 | drive |
  | 3 | trigger select |
  | 4 | edge polarity |
  | 5 | level polarity |
  | 6 | sleep block |
  | 7 | sleep drive |
  | 8 | fault drive |
  | 9 | event status |
  | 10 | alternate select |
  | 11 | sleep config |
  | 12 | pin level |

  Indexes 0-8, 10 and 11 are plain read/write. Indexes 13-15 read 0. An access with bus_addr[1:0]!=0 is ignored and reads 0.
- R3: pin_oe equals the direction register (1 = output). In normal mode pin_out equals the drive register.
- R4: pin_out takes its value by priority:
  - when batt_fault=1, the fault drive register, regardless of sleep_mode;
  - otherwise, when sleep_mode=1, the sleep drive register.
- R5: With trigger select bit = 0, a pin records an event on every cycle in which its synchronized level equals its level-polarity bit (0 = low, 1 = high).
- R6: With trigger select bit = 1, a pin records an event when two consecutive synchronized samples differ in the direction given by its edge-polarity bit (1 = rising, 0 = falling). A pin_in change made between edges appears in the status register after the third rising clock edge, and not after the second.
- R7: Status bits are sticky. Writing 1 to a status bit clears it and writing 0 leaves it. A detection in the same cycle as the clear leaves the bit set.
- R8: irq is the OR of status bits whose blocking bit is 0. The interrupt block register is used when sleep_mode=0, and the sleep block register when sleep_mode=1.
- R9: Reading index 12 returns the synchronized pin levels, two clock edges behind pin_in.
- R10: A write to index 12 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| pin_in | input | 16 | Raw pin levels |
| sleep_mode | input | 1 | Chip is in sleep |
| batt_fault | input | 1 | Battery fault condition |
| pin_out | output | 16 | Pin output values |
| pin_oe | output | 16 | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to bring about is a clear write that lands in the same cycle as a new detection on the same pin. From the ports this needs a pin level that stays active through the clear, and an edge that reaches the detector exactly three clock edges after the pin moved.

Directed steps hold a level-triggered pin active across a clear. Random stimulus mixes pin toggles, clears, polarity changes and sleep changes on every cycle. Each cycle the bench checks the result against a cycle-accurate reference of the synchronizer and status register built from the requirements.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
   // word index of each register (byte offset = index * 4)
   typedef enum logic [3:0] {
      RI_IRQ_BLOCK = 4'd0,
      RI_DIR       = 4'd1,
      RI_DRIVE     = 4'd2,
      RI_TRIG      = 4'd3,
      RI_EDGE_POL  = 4'd4,
      RI_LVL_POL   = 4'd5,
      RI_SLP_BLOCK = 4'd6,
      RI_SLP_DRIVE = 4'd7,
      RI_BF_DRIVE  = 4'd8,
      RI_EVENT     = 4'd9,
      RI_ALT       = 4'd10,
      RI_SLP_CFG   = 4'd11,
      RI_PIN_LVL   = 4'd12
   } reg_idx_e;
   localparam int unsigned NUM_CFG = 12;  // indexes below this hold storage
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_detect.sv
`timescale 1ns/1ps
module gpio_detect #(
   parameter int unsigned WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl,
   input  logic [WIDTH-1:0] trig,
   input  logic [WIDTH-1:0] edge_pol,
   input  logic [WIDTH-1:0] lvl_pol,
   output logic [WIDTH-1:0] hit
);
   logic [WIDTH-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   for (genvar g = 0; g < WIDTH; g++) begin : g_pin
      logic rise, fall;
      assign rise   = lvl[g] & ~prev_q[g];
      assign fall   = ~lvl[g] & prev_q[g];
      assign hit[g] = trig[g] ? (edge_pol[g] ? rise : fall)
                              : (lvl[g] == lvl_pol[g]);
   end

   // R6: an edge-mode hit needs a change since the previous cycle
   p_edge_needs_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((hit & trig & ~(lvl ^ $past(lvl))) == '0));
   // R5: a level-mode hit only on the active level
   p_level_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((hit & ~trig & (lvl ^ lvl_pol)) == '0));
endmodule

// File: rtl/gpio_outmux.sv
`timescale 1ns/1ps
module gpio_outmux #(
   parameter int unsigned WIDTH         = 16,
   parameter bit          FAULT_FIRST   = 1'b1
) (
   input  logic [WIDTH-1:0] drive,
   input  logic [WIDTH-1:0] slp_drive,
   input  logic [WIDTH-1:0] bf_drive,
   input  logic             sleep_mode,
   input  logic             batt_fault,
   output logic [WIDTH-1:0] pin_out
);
   if (FAULT_FIRST) begin : g_fault_first
      assign pin_out = batt_fault ? bf_drive :
                       sleep_mode ? slp_drive : drive;
   end else begin : g_sleep_first
      assign pin_out = sleep_mode ? slp_drive :
                       batt_fault ? bf_drive : drive;
   end
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NPINS       = 16,
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          FAULT_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [NPINS-1:0]  bus_wdata,
   output logic [NPINS-1:0]  bus_rdata,
   input  logic [NPINS-1:0]  pin_in,
   input  logic              sleep_mode,
   input  logic              batt_fault,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic              irq
);
   localparam int unsigned WORD_W = ADDR_W - 2;

   if (NPINS < 1 || NPINS > 32) begin : g_bad_pins
      $error("gpio_bank: NPINS must be 1..32");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("gpio_bank: ADDR_W must be at least 6");
   end

   logic [NUM_CFG-1:0][NPINS-1:0] cfg_q;
   logic [NPINS-1:0] evt_q, lvl, hit, clr, blk;
   logic [WORD_W-1:0] word;
   logic              aligned;

   assign word    = bus_addr[ADDR_W-1:2];
   assign aligned = (bus_addr[1:0] == 2'b00);

   gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl));

   gpio_detect #(.WIDTH(NPINS)) u_detect (
      .clk(clk), .rst_n(rst_n), .lvl(lvl),
      .trig(cfg_q[RI_TRIG]), .edge_pol(cfg_q[RI_EDGE_POL]),
      .lvl_pol(cfg_q[RI_LVL_POL]), .hit(hit));

   gpio_outmux #(.WIDTH(NPINS), .FAULT_FIRST(FAULT_FIRST)) u_outmux (
      .drive(cfg_q[RI_DRIVE]), .slp_drive(cfg_q[RI_SLP_DRIVE]),
      .bf_drive(cfg_q[RI_BF_DRIVE]), .sleep_mode(sleep_mode),
      .batt_fault(batt_fault), .pin_out(pin_out));

   // configuration storage
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (bus_wr && aligned) begin
         for (int i = 0; i < NUM_CFG; i++)
            if (word == WORD_W'(i) && i != int'(RI_EVENT)) cfg_q[i] <= bus_wdata;
      end
   end

   // sticky event status, write-1-to-clear, detection wins
   assign clr = (bus_wr && aligned && word == WORD_W'(RI_EVENT)) ? bus_wdata : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) evt_q <= '0;
      else        evt_q <= (evt_q & ~clr) | hit;
   end

   // read path
   always_comb begin
      bus_rdata = '0;
      if (aligned) begin
         if (word == WORD_W'(RI_EVENT))        bus_rdata = evt_q;
         else if (word == WORD_W'(RI_PIN_LVL)) bus_rdata = lvl;
         else
            for (int i = 0; i < NUM_CFG; i++)
               if (word == WORD_W'(i)) bus_rdata = cfg_q[i];
      end
   end

   assign pin_oe = cfg_q[RI_DIR];
   assign blk    = sleep_mode ? cfg_q[RI_SLP_BLOCK] : cfg_q[RI_IRQ_BLOCK];
   assign irq    = |(evt_q & ~blk);

   // R1: first cycle out of reset starts from a clean state
   p_reset_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (evt_q == '0 && cfg_q == '0));
   // R7: a set status bit only drops when written with 1
   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ##1 (($past(evt_q) & ~$past(clr) & ~evt_q) == '0));
   // R8: irq needs a pending status bit
   p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (evt_q != '0));
   // R10: a write to the pin-level index leaves all storage alone
   p_pinlvl_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && aligned && word == WORD_W'(RI_PIN_LVL)) |=> $stable(cfg_q));
endmodule

// File: tb/gpio_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [15:0] pin_in = 16'hFFFF;
   logic        sleep_mode = 1'b0;
   logic        batt_fault = 1'b0;
   logic [15:0] pin_out, pin_oe;
   logic        irq;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;  // 50 MHz

   gpio_bank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .sleep_mode(sleep_mode), .batt_fault(batt_fault),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

   // ---------------- reference model from the requirements ----------------
   logic [15:0] m_cfg [12];
   logic [15:0] m_s1, m_s2, m_prev, m_evt;

   function automatic logic [15:0] f_event(logic [15:0] s, logic [15:0] p,
         logic [15:0] tr, logic [15:0] ep, logic [15:0] lp);
      logic [15:0] e;
      for (int i = 0; i < 16; i++)
         if (tr[i]) e[i] = ep[i] ? (s[i] & ~p[i]) : (~s[i] & p[i]);
         else       e[i] = (s[i] == lp[i]);
      return e;
   endfunction

   function automatic logic f_irq(logic [15:0] ev, logic [15:0] b0,
                                  logic [15:0] b1, logic slp);
      return |(ev & ~(slp ? b1 : b0));
   endfunction

   function automatic logic [15:0] f_pout(logic [15:0] d, logic [15:0] sd,
                                          logic [15:0] bd, logic slp, logic bf);
      return bf ? bd : (slp ? sd : d);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 12; i++) m_cfg[i] <= '0;
         m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_evt <= '0;
      end else begin
         m_s1 <= pin_in; m_s2 <= m_s1; m_prev <= m_s2;
         m_evt <= (m_evt & ~((bus_wr && bus_addr == 6'h24) ? bus_wdata : 16'h0))
                  | f_event(m_s2, m_prev, m_cfg[3], m_cfg[4], m_cfg[5]);
         if (bus_wr && bus_addr[1:0] == 2'b00 && bus_addr[5:2] < 4'd12
             && bus_addr[5:2] != 4'd9)
            m_cfg[bus_addr[5:2]] <= bus_wdata;
      end
   end

   // ---------------- helpers ----------------
   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   task automatic wr(logic [5:0] a, logic [15:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      tick(1);
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [5:0] a, output logic [15:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   logic [15:0] v;

   initial begin
      // ---------- R1: reset state ----------
      tick(3);
      check("R1 pin_oe", pin_oe, 16'h0);
      check("R1 pin_out", pin_out, 16'h0);
      check("R1 irq", {15'h0, irq}, 16'h0);
      rd(6'h24, v); check("R1 status", v, 16'h0);
      rd(6'h04, v); check("R1 dir", v, 16'h0);
      rst_n = 1'b1;
      tick(1);
      // R5: default level-low detection on zeroed synchronizer
      rd(6'h24, v); check("R5 default low level", v, 16'hFFFF);

      // ---------- R2: read back storage ----------
      for (int i = 0; i < 12; i++)
         if (i != 9) wr(6'(i * 4), 16'h1111 * 16'(i) ^ 16'h5A00);
      for (int i = 0; i < 12; i++)
         if (i != 9) begin
            rd(6'(i * 4), v);
            check($sformatf("R2 readback idx %0d", i), v, 16'h1111 * 16'(i) ^ 16'h5A00);
         end
      wr(6'h05, 16'hDEAD);
      rd(6'h04, v); check("R2 misaligned write ignored", v, 16'h1111 ^ 16'h5A00);
      rd(6'h05, v); check("R2 misaligned read zero", v, 16'h0);
      rd(6'h34, v); check("R2 unmapped read zero", v, 16'h0);

      // ---------- R10: pin level index is read-only ----------
      wr(6'h30, 16'hFFFF);
      for (int i = 0; i < 12; i++)
         if (i != 9) begin
            rd(6'(i * 4), v);
            check($sformatf("R10 idx %0d unchanged", i), v, m_cfg[i]);
         end

      // ---------- R3 / R4: outputs ----------
      wr(6'h04, 16'hA5A5); wr(6'h08, 16'h0F0F);
      wr(6'h1C, 16'h1234); wr(6'h20, 16'h8001);
      #1;
      check("R3 pin_oe", pin_oe, 16'hA5A5);
      check("R3 pin_out normal", pin_out, 16'h0F0F);
      sleep_mode = 1'b1; #1;
      check("R4 sleep drive", pin_out, 16'h1234);
      batt_fault = 1'b1; #1;
      check("R4 fault over sleep", pin_out, 16'h8001);
      sleep_mode = 1'b0; #1;
      check("R4 fault alone", pin_out, 16'h8001);
      batt_fault = 1'b0; #1;
      check("R4 back to normal", pin_out, 16'h0F0F);

      // ---------- R9: pin level latency ----------
      pin_in = 16'hFFFE;
      tick(1); rd(6'h30, v); check("R9 one edge old", v, 16'hFFFF);
      tick(1); rd(6'h30, v); check("R9 two edges new", v, 16'hFFFE);

      // ---------- R6: edge detection ----------
      wr(6'h0C, 16'hFFFF);   // all edge
      wr(6'h10, 16'h00FF);   // low byte rising, high byte falling
      tick(2);
      wr(6'h24, 16'hFFFF);
      rd(6'h24, v); check("R6 cleared", v, 16'h0);
      pin_in = 16'hFFFF;     // bit0 rises
      tick(2); rd(6'h24, v); check("R6 not after two edges", v, 16'h0);
      tick(1); rd(6'h24, v); check("R6 rise after three edges", v, 16'h0001);
      pin_in = 16'hFEFE;     // bit8 falls (captured), bit0 falls (ignored)
      tick(3); rd(6'h24, v); check("R6 polarity", v, 16'h0101);

      // ---------- R7: sticky / clear vs level ----------
      pin_in = 16'hFFFF;
      tick(3);
      wr(6'h24, 16'hFFFF);
      wr(6'h14, 16'h0002);   // bit1 active high
      wr(6'h0C, 16'hFFFD);   // bit1 level mode
      tick(1);
      rd(6'h24, v); check("R5 level high sets", v, 16'h0002);
      wr(6'h24, 16'h0002);
      rd(6'h24, v); check("R7 clear loses to live level", v, 16'h0002);
      pin_in = 16'hFFFD;
      tick(3);
      wr(6'h24, 16'h0000);
      rd(6'h24, v); check("R7 write 0 keeps", v, 16'h0002);
      wr(6'h24, 16'h0002);
      rd(6'h24, v); check("R7 clear", v, 16'h0000);

      // ---------- R8: interrupt blocking ----------
      pin_in = 16'hFFFF;
      tick(3);
      wr(6'h00, 16'h0002); wr(6'h18, 16'h0000);
      #1; check("R8 blocked", {15'h0, irq}, 16'h0);
      wr(6'h00, 16'h0000);
      #1; check("R8 unblocked", {15'h0, irq}, 16'h1);
      wr(6'h18, 16'hFFFF); sleep_mode = 1'b1;
      #1; check("R8 sleep block used", {15'h0, irq}, 16'h0);
      wr(6'h18, 16'h0000);
      #1; check("R8 sleep unblocked", {15'h0, irq}, 16'h1);
      sleep_mode = 1'b0;

      // ---------- random mix against the reference ----------
      void'($urandom(32'd1234));
      for (int it = 0; it < 600; it++) begin
         int op;
         op = int'($urandom_range(0, 9));
         if ($urandom_range(0, 2) == 0) pin_in = pin_in ^ (16'h1 << $urandom_range(0, 15));
         if ($urandom_range(0, 15) == 0) sleep_mode = ~sleep_mode;
         if ($urandom_range(0, 31) == 0) batt_fault = ~batt_fault;
         if (op < 2) begin
            logic [3:0] ix;
            case ($urandom_range(0, 4))
               0: ix = 4'd0; 1: ix = 4'd3; 2: ix = 4'd4; 3: ix = 4'd5; default: ix = 4'd6;
            endcase
            bus_addr = {ix, 2'b00}; bus_wdata = 16'($urandom); bus_wr = 1'b1;
         end else if (op < 4) begin
            bus_addr = 6'h24; bus_wdata = 16'($urandom); bus_wr = 1'b1;
         end else begin
            bus_addr = 6'h24; bus_wr = 1'b0;
         end
         tick(1);
         bus_wr = 1'b0; bus_addr = 6'h24; #1;
         check("R7 random status", bus_rdata, m_evt);
         check("R8 random irq", {15'h0, irq},
               {15'h0, f_irq(m_evt, m_cfg[0], m_cfg[6], sleep_mode)});
         check("R4 random pin_out", pin_out,
               f_pout(m_cfg[2], m_cfg[7], m_cfg[8], sleep_mode, batt_fault));
         rd(6'h30, v); check("R9 random pin level", v, m_s2);
      end

      summary();
      $finish;
   end
endmodule